// File: doc/BRIEF.md
# Flush-to-Zero Half-Precision Dot-Product Accumulator

This block reduces two streams of 16-bit half-precision operands into one 32-bit single-precision sum. For each operand pair it performs one multiply-accumulate. The caller first pulses `acc_start` with a seed value on `acc_init`, which loads the running sum. It then pushes operand pairs over a valid/ready stream and marks the final pair with `in_last`. After that final term has been added, the block raises `res_valid` for one cycle and presents the rounded sum on `res_sum`.

Half-precision inputs with a zero exponent field are treated as zero before they are multiplied, so half-precision subnormals are flushed. The single-precision running sum keeps full gradual underflow. Each product of two half-precision significands fits exactly in single precision, so the multiplier never rounds. All rounding happens in the accumulate adder. That adder combines exactly one term per step, strictly in arrival order, and rounds to nearest-even using guard, round and sticky bits.

The stream applies back-pressure per term. `in_ready` is high only when the block is idle and no start pulse is present. A pair is taken on a rising clock edge where `in_valid` and `in_ready` are both high. `in_ready` then stays low for two cycles while the term is multiplied and added. A producer that sees `in_ready` low must keep `in_valid`, `in_a`, `in_b` and `in_last` unchanged until the transfer happens.

Top module: `mpd_dot_accum`

## Requirements
- R1: Transfer and back-pressure:
  - A pair transfers on a rising edge with `in_valid` and `in_ready` both high.
  - `in_ready` is low for the two cycles after that edge.
  - While `in_valid` is high and `in_ready` is low, the producer keeps the pair and `in_last` stable.
- R2: Start pulse:
  - While `acc_start` is high, `in_ready` is low.
  - In the idle state, a rising edge with `acc_start` high loads `acc_init` (IEEE single, bit 31 sign, bits 30:23 exponent, bits 22:0 fraction) into the running sum.
- R3: A half-precision operand (bit 15 sign, bits 14:10 exponent, bits 9:0 fraction) whose exponent field is 0 is used as a zero with its own sign. A vector whose terms all come from such operands returns the seed value bit-exactly, including a negative-zero seed.
- R4: The product of two finite, normal half-precision operands enters the sum with no rounding. For example, 0x3C01 times 0x3C01 from a +0 seed gives 0x3F804008.
- R5: Terms are added one at a time in arrival order, and each step is rounded. Seed 2^24 followed by terms 2 and 1 gives 0x4B800002. The same seed followed by terms 1 and 2 gives 0x4B800001.
- R6: Each step rounds to nearest with ties to even, and guard, round and sticky bits are kept beyond the 24-bit significand:
  - 2^24 + 1 gives 2^24, since a tie rounds to even.
  - 2^24 + (1 + 2^-10) rounds up to 0x4B800001.
- R7: Subnormal single-precision values in the running sum are kept and never flushed.
- R8: Special values:
  - A NaN operand gives the quiet NaN 0x7FC00000.
  - Infinity times zero gives 0x7FC00000, including infinity times a flushed subnormal.
  - Opposite infinities meeting in the sum give 0x7FC00000.
  - A NaN sum stays NaN through later terms.
  - An infinity plus a finite value gives that infinity.
  - A finite overflow after rounding gives a signed infinity.
- R9: An exact zero sum of operands with opposite signs is +0. The sum of two -0 values is -0.
- R10: `res_valid` is high for exactly one cycle, in the third cycle after the edge that accepted the pair flagged `in_last`. `res_sum` carries the final rounded sum in that cycle. Terms without the flag raise no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_start | input | 1 | Loads the seed into the running sum when idle |
| acc_init | input | 32 | Single-precision seed value |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_a | input | 16 | Half-precision operand A |
| in_b | input | 16 | Half-precision operand B |
| in_last | input | 1 | Marks the final pair of the vector |
| res_valid | output | 1 | One-cycle strobe with the final sum |
| res_sum | output | 32 | Single-precision result |

## Verification
The checker assumes that the producer never withdraws or changes a pair that is offered while `in_ready` is low. It also assumes that `acc_start` is not raised while a term is in flight. The bench raises `in_valid` only from idle-side negative edges and holds it, with the data, until an accepting edge. It pulses `acc_start` only after a result has been collected. The timing property for the result strobe therefore depends only on the accepting edge of the flagged pair.

// File: rtl/mpd_pkg.sv
package mpd_pkg;
  localparam int H_EXP_W  = 5;
  localparam int H_FRAC_W = 10;
  localparam int H_W      = 1 + H_EXP_W + H_FRAC_W;
  localparam int S_EXP_W  = 8;
  localparam int S_FRAC_W = 23;
  localparam int S_W      = 1 + S_EXP_W + S_FRAC_W;
  localparam int XBITS    = 3;                       // guard, round, sticky
  localparam int WORK_W   = S_FRAC_W + 1 + XBITS;    // hidden + fraction + extra
  localparam logic [S_W-1:0] CANON_QNAN = 32'h7FC0_0000;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_ADD} mpd_state_e;

  // count of leading zeros in the working significand
  function automatic logic [4:0] lead_zeros(input logic [WORK_W-1:0] v);
    lead_zeros = 5'(WORK_W);
    for (int i = 0; i < WORK_W; i++)
      if (v[i]) lead_zeros = 5'(WORK_W - 1 - i);
  endfunction
endpackage

// File: rtl/mpd_half_mul.sv
module mpd_half_mul
  import mpd_pkg::*;
(
  input  logic [H_W-1:0] op_a,
  input  logic [H_W-1:0] op_b,
  output logic [S_W-1:0] prod
);
  localparam int SIG_W = H_FRAC_W + 1;
  localparam int P_W   = 2 * SIG_W;
  localparam logic [H_EXP_W-1:0] EMAX = '1;

  logic             sa, sb, sp;
  logic [H_EXP_W-1:0]  ea, eb;
  logic [H_FRAC_W-1:0] fa, fb;
  logic a_zero, b_zero, a_inf, b_inf, a_nan, b_nan;
  logic [P_W-1:0] sig_p;
  logic [7:0]     esum;

  always_comb begin
    {sa, ea, fa} = op_a;
    {sb, eb, fb} = op_b;
    sp     = sa ^ sb;
    // zero exponent field covers true zeros and flushed subnormals
    a_zero = (ea == '0);
    b_zero = (eb == '0);
    a_inf  = (ea == EMAX) && (fa == '0);
    b_inf  = (eb == EMAX) && (fb == '0);
    a_nan  = (ea == EMAX) && (fa != '0);
    b_nan  = (eb == EMAX) && (fb != '0);
    sig_p  = P_W'({1'b1, fa}) * P_W'({1'b1, fb});
    esum   = {3'b0, ea} + {3'b0, eb};

    if (a_nan || b_nan || (a_inf && b_zero) || (b_inf && a_zero))
      prod = CANON_QNAN;
    else if (a_inf || b_inf)
      prod = {sp, 8'hFF, 23'h0};
    else if (a_zero || b_zero)
      prod = {sp, 31'h0};
    else if (sig_p[P_W-1])
      prod = {sp, esum + 8'd98, sig_p[P_W-2:0], 2'b00};
    else
      prod = {sp, esum + 8'd97, sig_p[P_W-3:0], 3'b000};
  end
endmodule

// File: rtl/mpd_f32_add.sv
module mpd_f32_add
  import mpd_pkg::*;
(
  input  logic [S_W-1:0] add_x,
  input  logic [S_W-1:0] add_y,
  output logic [S_W-1:0] add_sum
);
  localparam logic [S_EXP_W-1:0] EMAX = '1;

  logic              swap;
  logic              bs, ss;
  logic [S_EXP_W-1:0]  be, se, be_eff, se_eff, diff;
  logic [S_FRAC_W-1:0] bf, sf;
  logic x_nan, y_nan, x_inf, y_inf, eff_sub;
  logic [WORK_W-1:0] bm, sm, sm_sh, sm_al, mask, norm;
  logic [4:0]        sh, lz, shl;
  logic [S_EXP_W-1:0] lim;
  logic [WORK_W:0]   raw;
  logic [9:0]        ne, fe;
  logic              rnd_up;
  logic [S_FRAC_W+1:0] rm;
  logic [S_FRAC_W:0]   fm;

  always_comb begin
    x_nan = (add_x[30:23] == EMAX) && (add_x[22:0] != '0);
    y_nan = (add_y[30:23] == EMAX) && (add_y[22:0] != '0);
    x_inf = (add_x[30:23] == EMAX) && (add_x[22:0] == '0);
    y_inf = (add_y[30:23] == EMAX) && (add_y[22:0] == '0);

    swap = add_y[30:0] > add_x[30:0];
    {bs, be, bf} = swap ? add_y : add_x;
    {ss, se, sf} = swap ? add_x : add_y;
    be_eff  = (be == '0) ? 8'd1 : be;
    se_eff  = (se == '0) ? 8'd1 : se;
    bm      = {be != '0, bf, 3'b000};
    sm      = {se != '0, sf, 3'b000};
    eff_sub = bs ^ ss;

    // align the smaller term, folding every lost bit into sticky
    diff  = be_eff - se_eff;
    sh    = (diff > 8'(WORK_W)) ? 5'(WORK_W) : diff[4:0];
    mask  = ~({WORK_W{1'b1}} << sh);
    sm_sh = sm >> sh;
    sm_al = {sm_sh[WORK_W-1:1], sm_sh[0] | (|(sm & mask))};

    raw = eff_sub ? ({1'b0, bm} - {1'b0, sm_al}) : ({1'b0, bm} + {1'b0, sm_al});

    lz  = lead_zeros(raw[WORK_W-1:0]);
    lim = be_eff - 8'd1;
    if (raw[WORK_W]) begin
      shl  = '0;
      norm = {raw[WORK_W:2], raw[1] | raw[0]};
      ne   = {2'b0, be_eff} + 10'd1;
    end else begin
      // stop at the minimum exponent so that subnormals survive
      shl  = ({3'b0, lz} < lim) ? lz : lim[4:0];
      norm = raw[WORK_W-1:0] << shl;
      ne   = {2'b0, be_eff} - {5'b0, shl};
    end

    rnd_up = norm[2] & (norm[1] | norm[0] | norm[3]);
    rm     = {1'b0, norm[WORK_W-1:3]} + {{(S_FRAC_W+1){1'b0}}, rnd_up};
    if (rm[S_FRAC_W+1]) begin
      fm = rm[S_FRAC_W+1:1];
      fe = ne + 10'd1;
    end else begin
      fm = rm[S_FRAC_W:0];
      fe = ne;
    end

    if (x_nan || y_nan || (x_inf && y_inf && (add_x[31] != add_y[31])))
      add_sum = CANON_QNAN;
    else if (x_inf)
      add_sum = add_x;
    else if (y_inf)
      add_sum = add_y;
    else if (raw == '0)
      add_sum = {eff_sub ? 1'b0 : bs, 31'h0};
    else if (fe >= 10'd255)
      add_sum = {bs, 8'hFF, 23'h0};
    else
      add_sum = {bs, fm[S_FRAC_W] ? fe[7:0] : 8'h00, fm[S_FRAC_W-1:0]};
  end
endmodule

// File: rtl/mpd_dot_accum.sv
module mpd_dot_accum
  import mpd_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           acc_start,
  input  logic [S_W-1:0] acc_init,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [H_W-1:0] in_a,
  input  logic [H_W-1:0] in_b,
  input  logic           in_last,
  output logic           res_valid,
  output logic [S_W-1:0] res_sum
);
  mpd_state_e     state;
  logic [H_W-1:0] op_a_q, op_b_q;
  logic           op_last_q, prod_last_q;
  logic [S_W-1:0] prod_d, prod_q, acc_q, sum_d;

  mpd_half_mul u_mul (.op_a(op_a_q), .op_b(op_b_q), .prod(prod_d));
  mpd_f32_add  u_add (.add_x(acc_q), .add_y(prod_q), .add_sum(sum_d));

  assign in_ready = (state == ST_IDLE) && !acc_start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      op_a_q      <= '0;
      op_b_q      <= '0;
      op_last_q   <= 1'b0;
      prod_q      <= '0;
      prod_last_q <= 1'b0;
      acc_q       <= '0;
      res_valid   <= 1'b0;
      res_sum     <= '0;
    end else begin
      res_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (acc_start) begin
            acc_q <= acc_init;
          end else if (in_valid) begin
            op_a_q    <= in_a;
            op_b_q    <= in_b;
            op_last_q <= in_last;
            state     <= ST_MUL;
          end
        end
        ST_MUL: begin
          prod_q      <= prod_d;
          prod_last_q <= op_last_q;
          state       <= ST_ADD;
        end
        ST_ADD: begin
          acc_q <= sum_d;
          if (prod_last_q) begin
            res_valid <= 1'b1;
            res_sum   <= sum_d;
          end
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mpd_dot_accum_chk.sv
module mpd_dot_accum_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        acc_start,
  input logic        in_valid,
  input logic        in_ready,
  input logic [15:0] in_a,
  input logic [15:0] in_b,
  input logic        in_last,
  input logic        res_valid,
  input logic [31:0] res_sum
);
  p_busy_after_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_hold_stream_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !acc_start) |=>
      (in_valid && $stable(in_a) && $stable(in_b) && $stable(in_last)));

  p_start_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |-> !in_ready);

  p_qnan_canonical_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (res_sum[30:23] == 8'hFF) && (res_sum[22:0] != 23'h0)) |->
      (res_sum[22:0] == 23'h40_0000));

  p_result_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_result_after_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(in_valid && in_ready && in_last, 3));
endmodule

bind mpd_dot_accum mpd_dot_accum_chk u_chk (
  .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .in_valid(in_valid),
  .in_ready(in_ready), .in_a(in_a), .in_b(in_b), .in_last(in_last),
  .res_valid(res_valid), .res_sum(res_sum)
);

// File: tb/sim_mpd_dot_accum.sv
module sim_mpd_dot_accum;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_start = 1'b0;
  logic [31:0] acc_init = '0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_a = '0;
  logic [15:0] in_b = '0;
  logic        in_last = 1'b0;
  logic        res_valid;
  logic [31:0] res_sum;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [15:0] va [8];
  logic [15:0] vb [8];

  always #4 clk = ~clk;

  mpd_dot_accum u0 (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .acc_init(acc_init),
    .in_valid(in_valid), .in_ready(in_ready), .in_a(in_a), .in_b(in_b),
    .in_last(in_last), .res_valid(res_valid), .res_sum(res_sum)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic start_acc(input logic [31:0] init);
    @(negedge clk);
    acc_start = 1'b1;
    acc_init  = init;
    #1;
    chk("R2 ready low during start", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    acc_start = 1'b0;
  endtask

  task automatic push(input logic [15:0] a, input logic [15:0] b, input logic last);
    int cnt = 0;
    in_a = a; in_b = b; in_last = last; in_valid = 1'b1;
    while (in_ready !== 1'b1 && cnt < 50) begin
      @(negedge clk);
      cnt++;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_result(input string req, input logic [31:0] exp);
    int cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while (res_valid !== 1'b1 && cnt < 20);
    chk("R10 latency", 32'(cnt), 32'd3);
    chk(req, res_sum, exp);
    @(negedge clk);
    chk("R10 single pulse", {31'b0, res_valid}, 32'd0);
  endtask

  task automatic run_case(input string req, input logic [31:0] init, input int n,
                          input logic [31:0] exp);
    start_acc(init);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      push(va[i], vb[i], i == n - 1);
    end
    wait_result(req, exp);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 ready after reset", {31'b0, in_ready}, 32'd1);
    chk("R10 no result after reset", {31'b0, res_valid}, 32'd0);
  endtask

  task automatic t_timing;
    start_acc(32'h0);
    @(negedge clk);
    push(16'h3C00, 16'h3C00, 1'b0);
    @(negedge clk);
    chk("R1 busy cycle 1", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R1 busy cycle 2", {31'b0, in_ready}, 32'd0);
    @(negedge clk);
    chk("R10 no strobe without last", {31'b0, res_valid}, 32'd0);
    chk("R1 ready again", {31'b0, in_ready}, 32'd1);
    push(16'h4000, 16'h3C00, 1'b1);
    wait_result("R1 two-term sum", 32'h4040_0000);
  endtask

  task automatic t_basic;
    va[0] = 16'h3C00; vb[0] = 16'h4000;
    va[1] = 16'h4200; vb[1] = 16'h3800;
    va[2] = 16'hB800; vb[2] = 16'h4400;
    run_case("R5 mixed-sign sum", 32'h0, 3, 32'h3FC0_0000);
    va[0] = 16'h4000; vb[0] = 16'h4000;
    run_case("R2 seed loaded", 32'h3F80_0000, 1, 32'h40A0_0000);
  endtask

  task automatic t_ftz;
    va[0] = 16'h0001; vb[0] = 16'h3C00;
    va[1] = 16'h03FF; vb[1] = 16'h7BFF;
    run_case("R3 all subnormal from zero", 32'h0, 2, 32'h0);
    va[0] = 16'h8200; vb[0] = 16'h3C00;
    run_case("R3 subnormal keeps seed", 32'h3F80_0000, 1, 32'h3F80_0000);
    run_case("R3 negative flushed sign", 32'h8000_0000, 1, 32'h8000_0000);
  endtask

  task automatic t_exact;
    va[0] = 16'h3C01; vb[0] = 16'h3C01;
    run_case("R4 exact small product", 32'h0, 1, 32'h3F80_4008);
    va[0] = 16'h7BFF; vb[0] = 16'h7BFF;
    run_case("R4 exact largest product", 32'h0, 1, 32'h4F7F_C004);
    va[0] = 16'h0400; vb[0] = 16'h0400;
    run_case("R4 smallest normal product", 32'h0, 1, 32'h3180_0000);
  endtask

  task automatic t_order_rne;
    va[0] = 16'h3C00; vb[0] = 16'h3C00;
    run_case("R6 tie to even", 32'h4B80_0000, 1, 32'h4B80_0000);
    va[0] = 16'h3C00; vb[0] = 16'h3C01;
    run_case("R6 sticky above tie", 32'h4B80_0000, 1, 32'h4B80_0001);
    va[0] = 16'h4000; vb[0] = 16'h3C00;
    va[1] = 16'h3C00; vb[1] = 16'h3C00;
    run_case("R5 order two then one", 32'h4B80_0000, 2, 32'h4B80_0002);
    va[0] = 16'h3C00; vb[0] = 16'h3C00;
    va[1] = 16'h4000; vb[1] = 16'h3C00;
    run_case("R5 order one then two", 32'h4B80_0000, 2, 32'h4B80_0001);
  endtask

  task automatic t_sub_acc;
    va[0] = 16'h0000; vb[0] = 16'h3C00;
    run_case("R7 positive subnormal seed", 32'h0000_0003, 1, 32'h0000_0003);
    run_case("R7 negative subnormal seed", 32'h8000_0005, 1, 32'h8000_0005);
  endtask

  task automatic t_special;
    va[0] = 16'h7E00; vb[0] = 16'h3C00;
    run_case("R8 NaN operand", 32'h0, 1, 32'h7FC0_0000);
    va[0] = 16'h7C00; vb[0] = 16'h0001;
    run_case("R8 inf times flushed", 32'h0, 1, 32'h7FC0_0000);
    va[0] = 16'h7C00; vb[0] = 16'h3C00;
    run_case("R8 opposite infinities", 32'hFF80_0000, 1, 32'h7FC0_0000);
    va[0] = 16'h7C00; vb[0] = 16'hC000;
    run_case("R8 infinity plus finite", 32'h0, 1, 32'hFF80_0000);
    va[0] = 16'h7E00; vb[0] = 16'h3C00;
    va[1] = 16'h3C00; vb[1] = 16'h3C00;
    run_case("R8 NaN persists", 32'h0, 2, 32'h7FC0_0000);
  endtask

  task automatic t_zero_sign;
    va[0] = 16'hBC00; vb[0] = 16'h3C00;
    run_case("R9 cancel to plus zero", 32'h3F80_0000, 1, 32'h0);
    va[0] = 16'h8000; vb[0] = 16'h3C00;
    run_case("R9 minus zero pair", 32'h8000_0000, 1, 32'h8000_0000);
    va[0] = 16'h0000; vb[0] = 16'h3C00;
    run_case("R9 mixed zero signs", 32'h8000_0000, 1, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_timing();
    t_basic();
    t_ftz();
    t_exact();
    t_order_rne();
    t_sub_acc();
    t_special();
    t_zero_sign();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(8 * 100000);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule